// File: doc/BRIEF.md
# Serial Unlock Key Detector

This block watches a two-wire serial clock/data pair and recognises a fixed 32-bit unlock word. When it sees the word, the device enters program mode without a raised supply on the reset pin. Both serial lines reach the block already synchronised to a fast system clock. The block samples one data bit on each falling edge of the serial clock. Bits arrive least-significant first. After every sampled bit, the block compares the last 32 bits against the key.

Detection has two gates. The low-voltage-entry enable bit must be 1, and the active-low reset-select line must be held low. A matching key alone is not enough: one further serial clock must follow it before the block raises the program-mode flag. At that moment the block also emits a single-cycle entry pulse. The surrounding logic uses this pulse to reset itself and clear its address counter. The flag stays set for as long as reset-select stays low. Releasing the line leaves program mode and wipes any partly shifted key.

Top module: `unlock_key_detect`

## Requirements
- R1: After system reset, progMode and entryPulse are both 0.
- R2: A data bit is taken only on a falling edge of serClk. Bits enter least-significant first, so the first bit shifted lands at bit 0 of the 32-bit word. The word accepted is 0x4D434850.
- R3: A matching word by itself does not set progMode. progMode is set on the first serClk falling edge after the 32nd key bit, which is the 33rd edge.
- R4: While lvEnable is 0, no key is accepted and progMode never rises.
- R5: When selN is sampled high, progMode is 0 from the next clock on. Once selN is low again, a new entry is possible.
- R6: While selN is high, the bit history is cleared, so a partial key never carries over into the next attempt.
- R7: The comparison is made after every sampled bit. Any number of unrelated bits may come before a correct key, and the key still unlocks.
- R8: A word that differs from the key in any one bit does not set progMode.
- R9: entryPulse is high for exactly one clock on each entry, in the same cycle that progMode first reads 1.
- R10: Detection works when selN is already low at reset release, with no falling edge of selN ever seen.
- R11: While in program mode with selN low, further serial traffic leaves progMode at 1 and produces no further entryPulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| serClk | input | 1 | Serial clock, already synchronised to clk |
| serDat | input | 1 | Serial data, already synchronised to clk |
| selN | input | 1 | Active-low reset-select level; must be low to enter and to hold program mode |
| lvEnable | input | 1 | Low-voltage-entry enable bit |
| progMode | output | 1 | Program-mode flag |
| entryPulse | output | 1 | Single-cycle pulse on entry into program mode |

## Verification
The bench builds the block with its default parameters: a 32-bit key of 0x4D434850 and one trailing clock. These values exercise the exact extra-clock rule and the real key value. The bench can therefore show that 32 correct bits alone leave the flag low and that the next edge sets it. With the 32-bit width, single-bit flips at either end of the word can be tried, as can a half key cut off by a release of selN and a key that follows unrelated bits.

// File: rtl/unlock_pkg.sv
`timescale 1ns/1ps
package unlock_pkg;

  // strobes from the sequencer to the shift path
  typedef struct packed {
    logic shiftEn;     // accept new bits into the history
    logic clearShift;  // wipe the history
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_PROG  = 2'd2
  } ctlState_t;

endpackage

// File: rtl/unlock_shift_path.sv
`timescale 1ns/1ps
module unlock_shift_path
  import unlock_pkg::*;
#(
  parameter int unsigned KEY_WIDTH = 32,
  parameter logic [KEY_WIDTH-1:0] KEY_VALUE = 32'h4D43_4850
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      serClk,
  input  logic      serDat,
  input  dpStrobe_t strobe,
  output logic      bitStrobe,
  output logic      keyMatch
);

  localparam int unsigned TOP = KEY_WIDTH - 1;

  logic                 serClkQ;
  logic                 fallEdge;
  logic [KEY_WIDTH-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) serClkQ <= 1'b0;
    else       serClkQ <= serClk;
  end

  assign fallEdge = serClkQ & ~serClk;

  // least-significant bit first: new bit enters at the top, moves down
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.clearShift) begin
      shiftReg <= '0;
    end else if (strobe.shiftEn && fallEdge) begin
      shiftReg <= {serDat, shiftReg[TOP:1]};
    end
  end

  // one cycle after each sampled edge, with history already updated
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitStrobe <= 1'b0;
    else       bitStrobe <= fallEdge & ~strobe.clearShift;
  end

  assign keyMatch = (shiftReg == KEY_VALUE);

  // R6
  shift_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearShift |=> (shiftReg == '0));

  // R2
  hold_no_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fallEdge && !strobe.clearShift) |=> $stable(shiftReg));

endmodule

// File: rtl/unlock_ctrl.sv
`timescale 1ns/1ps
module unlock_ctrl
  import unlock_pkg::*;
#(
  parameter int unsigned TAIL_CLOCKS = 1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      selN,
  input  logic      lvEnable,
  input  logic      bitStrobe,
  input  logic      keyMatch,
  output dpStrobe_t strobe,
  output logic      progMode,
  output logic      entryPulse
);

  localparam int unsigned CNT_W = $clog2(TAIL_CLOCKS + 2);
  localparam int unsigned LAST  = (TAIL_CLOCKS > 0) ? TAIL_CLOCKS - 1 : 0;

  ctlState_t        state, stateNext;
  logic [CNT_W-1:0] tailCnt, tailCntNext;
  logic             pulseNext;

  always_comb begin
    strobe.clearShift = selN;
    strobe.shiftEn    = (state == ST_IDLE) && !selN;
  end

  always_comb begin
    stateNext   = state;
    tailCntNext = tailCnt;
    pulseNext   = 1'b0;
    if (selN) begin
      stateNext   = ST_IDLE;
      tailCntNext = '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (bitStrobe && keyMatch && lvEnable) begin
            tailCntNext = '0;
            if (TAIL_CLOCKS == 0) begin
              stateNext = ST_PROG;
              pulseNext = 1'b1;
            end else begin
              stateNext = ST_ARMED;
            end
          end
        end
        ST_ARMED: begin
          if (!lvEnable) begin
            stateNext   = ST_IDLE;
            tailCntNext = '0;
          end else if (bitStrobe) begin
            if (tailCnt == CNT_W'(LAST)) begin
              stateNext = ST_PROG;
              pulseNext = 1'b1;
            end else begin
              tailCntNext = tailCnt + 1'b1;
            end
          end
        end
        ST_PROG: stateNext = ST_PROG;
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      tailCnt    <= '0;
      entryPulse <= 1'b0;
    end else begin
      state      <= stateNext;
      tailCnt    <= tailCntNext;
      entryPulse <= pulseNext;
    end
  end

  assign progMode = (state == ST_PROG);

  // R5
  release_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    selN |=> !progMode);

  // R9
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    entryPulse |=> !entryPulse);

  // R9
  pulse_on_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progMode) |-> entryPulse);

  // R4
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progMode) |-> $past(lvEnable));

  // R11
  prog_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (progMode && !selN) |=> progMode);

endmodule

// File: rtl/unlock_key_detect.sv
`timescale 1ns/1ps
module unlock_key_detect
  import unlock_pkg::*;
#(
  parameter int unsigned KEY_WIDTH   = 32,
  parameter logic [KEY_WIDTH-1:0] KEY_VALUE = 32'h4D43_4850,
  parameter int unsigned TAIL_CLOCKS = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic serClk,
  input  logic serDat,
  input  logic selN,
  input  logic lvEnable,
  output logic progMode,
  output logic entryPulse
);

  dpStrobe_t strobe;
  logic      bitStrobe;
  logic      keyMatch;

  unlock_shift_path #(
    .KEY_WIDTH (KEY_WIDTH),
    .KEY_VALUE (KEY_VALUE)
  ) i_path (
    .clk       (clk),
    .rstN      (rstN),
    .serClk    (serClk),
    .serDat    (serDat),
    .strobe    (strobe),
    .bitStrobe (bitStrobe),
    .keyMatch  (keyMatch)
  );

  unlock_ctrl #(
    .TAIL_CLOCKS (TAIL_CLOCKS)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .selN       (selN),
    .lvEnable   (lvEnable),
    .bitStrobe  (bitStrobe),
    .keyMatch   (keyMatch),
    .strobe     (strobe),
    .progMode   (progMode),
    .entryPulse (entryPulse)
  );

endmodule

// File: tb/test_unlock_key_detect.sv
`timescale 1ns/1ps
module test_unlock_key_detect;

  localparam logic [31:0] KEY = 32'h4D43_4850;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0;
  logic serDat = 1'b0;
  logic selN = 1'b0;
  logic lvEnable = 1'b1;
  logic progMode, entryPulse;

  int errors = 0;
  int checks = 0;
  int pulseCnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  unlock_key_detect i_unlock_key_detect (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serDat(serDat),
    .selN(selN), .lvEnable(lvEnable),
    .progMode(progMode), .entryPulse(entryPulse)
  );

  // count pulses and check their alignment, away from the active edge
  always @(negedge clk) begin
    if (entryPulse) begin
      pulseCnt++;
      checks++;
      if (!progMode) begin
        errors++;
        $display("FAIL R9 progMode during pulse actual=%0b expected=1", progMode);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk); serDat = b; serClk = 1'b1;
    repeat (2) @(negedge clk);
    serClk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic sendWord(input logic [31:0] w, input int n);
    for (int i = 0; i < n; i++) sendBit(w[i]);
  endtask

  task automatic release_sel();
    @(negedge clk); selN = 1'b1;
    repeat (3) @(negedge clk);
    selN = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // {enable, send trailing clock, expect entry, word}
  localparam int NV = 6;
  localparam logic [34:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b1, KEY},                   // R2 R3 good key
    {1'b1, 1'b1, 1'b0, KEY ^ 32'h0000_0001},   // R8 first bit flipped
    {1'b1, 1'b1, 1'b0, KEY ^ 32'h8000_0000},   // R8 last bit flipped
    {1'b1, 1'b1, 1'b0, KEY ^ 32'h0001_0000},   // R8 middle bit flipped
    {1'b0, 1'b1, 1'b0, KEY},                   // R4 enable off
    {1'b1, 1'b0, 1'b0, KEY}                    // R3 no trailing clock
  };

  initial begin
    int p0;
    // R1 reset state, selN already low from time zero
    repeat (3) @(negedge clk);
    check(progMode == 1'b0, "R1 progMode", progMode, 0);
    check(entryPulse == 1'b0, "R1 entryPulse", entryPulse, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R10 entry with no falling edge of selN; R3 32 bits are not enough
    p0 = pulseCnt;
    sendWord(KEY, 32);
    check(progMode == 1'b0, "R3 after 32 bits", progMode, 0);
    sendBit(1'b0);
    check(progMode == 1'b1, "R10 entry at power-up low", progMode, 1);
    check(pulseCnt - p0 == 1, "R9 one pulse", pulseCnt - p0, 1);

    // R11 traffic in program mode
    p0 = pulseCnt;
    sendWord(32'hA5C3_0F96, 32);
    sendWord(KEY, 32);
    sendBit(1'b1);
    check(progMode == 1'b1, "R11 stays set", progMode, 1);
    check(pulseCnt == p0, "R11 no extra pulse", pulseCnt - p0, 0);

    // R5 release exits on next clock
    @(negedge clk); selN = 1'b1;
    @(negedge clk);
    check(progMode == 1'b0, "R5 exit", progMode, 0);
    repeat (2) @(negedge clk);
    selN = 1'b0;
    repeat (2) @(negedge clk);

    // table walk
    for (int v = 0; v < NV; v++) begin
      release_sel();
      lvEnable = VEC[v][34];
      p0 = pulseCnt;
      sendWord(VEC[v][31:0], 32);
      if (VEC[v][33]) sendBit(1'b0);
      repeat (3) @(negedge clk);
      check(progMode == VEC[v][32], $sformatf("R2 R3 R4 R8 vector %0d", v),
            progMode, VEC[v][32]);
      check(pulseCnt - p0 == int'(VEC[v][32]), $sformatf("R9 vector %0d pulses", v),
            pulseCnt - p0, VEC[v][32]);
    end
    lvEnable = 1'b1;

    // R6 partial key wiped by release
    release_sel();
    sendWord(KEY, 16);
    release_sel();
    sendWord(KEY >> 16, 16);
    sendBit(1'b0);
    check(progMode == 1'b0, "R6 partial key", progMode, 0);

    // R7 garbage before key; R5 re-entry after exit
    sendWord(32'h0000_FFFF, 16);
    sendWord(KEY, 32);
    sendBit(1'b1);
    check(progMode == 1'b1, "R7 key after garbage", progMode, 1);
    release_sel();
    check(progMode == 1'b0, "R5 released", progMode, 0);
    sendWord(KEY, 32);
    sendBit(1'b0);
    check(progMode == 1'b1, "R5 re-entry", progMode, 1);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule